// File: doc/BRIEF.md
# Masked Packed Multiply-Low Unit

This SIMD integer execution unit treats its two source vectors as packed signed 16-bit lanes. It multiplies each lane pair and keeps only the low 16 bits of each product, so overflow wraps with no error. A mode select picks how many lanes take part and what happens to the rest of the 512-bit destination. The rest is either kept from the old destination value, cleared to zero, or decided per lane by a write mask with merge or zero handling.

An operation is a single input beat carrying:

- both sources;
- the old destination value;
- the mask;
- the mode and length codes.

The result leaves as a single output beat. Both edges use a valid/ready handshake:

- A beat is accepted on a rising clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or being drained in the same cycle.
- A result held while `out_ready` is low stays unchanged, and no new input is taken.

Mode codes on `in_mode`:

| Code | Mode |
|---|---|
| 0 | Four-lane |
| 1 | Legacy 128 |
| 2 | Unmasked vector |
| 3 | Merge-masked |
| 4 | Zero-masked |
| 5 to 7 | Illegal |

Length codes on `in_len`:

| Code | Vector length |
|---|---|
| 0 | 128 bits (8 lanes) |
| 1 | 256 bits (16 lanes) |
| 2 | 512 bits (32 lanes) |
| 3 | Illegal |

Lane j occupies bits [16j+15:16j] of every vector. Bit j of `in_mask` belongs to lane j.

Top module: `pmlo_unit`

## Requirements
- R1: Each computed lane receives bits [15:0] of the full 32-bit signed product of its two 16-bit elements. Overflow is dropped with no flag; for example, 0x8000 x 0x8000 gives 0x0000 and 0x8000 x 0xFFFF gives 0x8000.
- R2: Mode 0 computes lanes 0 to 3, copies result bits 511:64 from `in_old`, and ignores `in_len` and `in_mask`.
- R3: Mode 1 computes lanes 0 to 7, copies result bits 511:128 from `in_old`, and ignores `in_len` and `in_mask`.
- R4: Mode 2 computes every lane below the active length given by `in_len` (0=128, 1=256, 2=512 bits) and clears all bits above it.
- R5: Mode 3 places the product in an active lane whose mask bit is 1 and keeps the `in_old` lane where the mask bit is 0. Bits above the active length are cleared.
- R6: Mode 4 places the product in an active lane whose mask bit is 1 and writes zero where the mask bit is 0. Bits above the active length are cleared.
- R7: Mask bits at or above the active lane count have no effect on the result.
- R8: Mode codes 5 to 7, and length code 3 in modes 2 to 4, return `in_old` unchanged with `out_illegal` high for that result beat only. Every legal operation returns `out_illegal` low.
- R9: A beat accepted on one edge shows its result with `out_valid` high after that same edge. The result stays stable while `out_ready` is low, with `in_ready` low. `out_valid` drops after the result is taken if no new beat arrives.
- R10: While synchronous active-high `rst` is asserted, `out_valid` and `out_illegal` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can accept a beat |
| in_mode | input | 3 | Operating mode code |
| in_len | input | 2 | Vector length code |
| in_mask | input | 32 | Per-lane write mask |
| in_src1 | input | 512 | First packed source |
| in_src2 | input | 512 | Second packed source |
| in_old | input | 512 | Old destination value |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 512 | Packed result |
| out_illegal | output | 1 | Mode or length code was invalid |

## Verification
The bench builds the unit with its default parameters: 16-bit lanes, 32 lanes, and the truncating lane multiplier. At these values every vector length from 128 to 512 bits can be exercised, as can every mask bit and every mode. The truncated multiplier is compared lane by lane against a full signed 32-bit product. Operand patterns include the wrap cases at the extremes of the signed range.

// File: rtl/pmlo_pkg.sv
package pmlo_pkg;

  typedef enum logic [2:0] {
    MD_QUAD4  = 3'd0,
    MD_LEG128 = 3'd1,
    MD_VEC    = 3'd2,
    MD_MRG    = 3'd3,
    MD_ZRO    = 3'd4
  } pmlo_mode_e;

  typedef enum logic [1:0] {
    LN_128 = 2'd0,
    LN_256 = 2'd1,
    LN_512 = 2'd2,
    LN_BAD = 2'd3
  } pmlo_len_e;

  // Active vector length in bits for a legal length code.
  function automatic int unsigned vl_bits(input logic [1:0] code);
    return 32'd128 << code;
  endfunction

endpackage

// File: rtl/pmlo_lane_mul.sv
module pmlo_lane_mul #(
  parameter int unsigned LANE_W = 16,
  parameter bit          TRUNC  = 1'b1
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] lo
);

  generate
    if (TRUNC) begin : g_trunc
      // Low half is the same for signed and unsigned operands.
      assign lo = a * b;
    end else begin : g_full
      logic signed [2*LANE_W-1:0] full;
      assign full = $signed(a) * $signed(b);
      assign lo   = full[LANE_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/pmlo_lane_ctrl.sv
module pmlo_lane_ctrl
  import pmlo_pkg::*;
#(
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned MAX_LANES = 32
) (
  input  logic [2:0]           mode,
  input  logic [1:0]           len,
  input  logic [MAX_LANES-1:0] mask,
  output logic [MAX_LANES-1:0] take_prod,
  output logic [MAX_LANES-1:0] take_old,
  output logic                 illegal
);

  localparam int unsigned QUAD_LANES = 64 / LANE_W;
  localparam int unsigned LEG_LANES  = 128 / LANE_W;

  int unsigned active;
  logic        masked;
  logic        merge;
  logic        fill_zero;

  // Mode decode: lane count, masking style, handling of the upper part.
  always_comb begin
    active    = 0;
    masked    = 1'b0;
    merge     = 1'b0;
    fill_zero = 1'b1;
    illegal   = 1'b0;
    case (pmlo_mode_e'(mode))
      MD_QUAD4: begin
        active    = QUAD_LANES;
        fill_zero = 1'b0;
      end
      MD_LEG128: begin
        active    = LEG_LANES;
        fill_zero = 1'b0;
      end
      MD_VEC, MD_MRG, MD_ZRO: begin
        if (pmlo_len_e'(len) == LN_BAD) illegal = 1'b1;
        else active = vl_bits(len) / LANE_W;
        masked = (pmlo_mode_e'(mode) != MD_VEC);
        merge  = (pmlo_mode_e'(mode) == MD_MRG);
      end
      default: illegal = 1'b1;
    endcase
  end

  // Per-lane source select: product, old value, or zero (neither set).
  always_comb begin
    for (int unsigned j = 0; j < MAX_LANES; j++) begin
      take_prod[j] = 1'b0;
      take_old[j]  = 1'b0;
      if (illegal) begin
        take_old[j] = 1'b1;
      end else if (j < active) begin
        if (masked && !mask[j]) take_old[j] = merge;
        else                    take_prod[j] = 1'b1;
      end else begin
        take_old[j] = !fill_zero;
      end
    end
  end

endmodule

// File: rtl/pmlo_unit.sv
module pmlo_unit
  import pmlo_pkg::*;
#(
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned MAX_LANES = 32,
  parameter bit          TRUNC_MUL = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [2:0]                  in_mode,
  input  logic [1:0]                  in_len,
  input  logic [MAX_LANES-1:0]        in_mask,
  input  logic [LANE_W*MAX_LANES-1:0] in_src1,
  input  logic [LANE_W*MAX_LANES-1:0] in_src2,
  input  logic [LANE_W*MAX_LANES-1:0] in_old,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [LANE_W*MAX_LANES-1:0] out_data,
  output logic                        out_illegal
);

  localparam int unsigned DW     = LANE_W * MAX_LANES;
  localparam int unsigned QUAD_W = 64;

  logic [MAX_LANES-1:0] take_prod;
  logic [MAX_LANES-1:0] take_old;
  logic                 illegal;
  logic [DW-1:0]        nxt;
  logic [LANE_W-1:0]    prod [MAX_LANES];
  logic                 in_fire;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  pmlo_lane_ctrl #(
    .LANE_W    (LANE_W),
    .MAX_LANES (MAX_LANES)
  ) u_ctrl (
    .mode      (in_mode),
    .len       (in_len),
    .mask      (in_mask),
    .take_prod (take_prod),
    .take_old  (take_old),
    .illegal   (illegal)
  );

  generate
    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
      pmlo_lane_mul #(
        .LANE_W (LANE_W),
        .TRUNC  (TRUNC_MUL)
      ) u_mul (
        .a  (in_src1[g*LANE_W +: LANE_W]),
        .b  (in_src2[g*LANE_W +: LANE_W]),
        .lo (prod[g])
      );
      assign nxt[g*LANE_W +: LANE_W] =
        take_prod[g] ? prod[g] :
        take_old[g]  ? in_old[g*LANE_W +: LANE_W] : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end else if (in_fire) begin
      out_valid   <= 1'b1;
      out_data    <= nxt;
      out_illegal <= illegal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end
  end

  // R9: accepted beat is visible after the accepting edge
  a_r9_result_follows_accept: assert property (@(posedge clk) disable iff (rst)
    in_fire |=> out_valid);

  // R9: a stalled result is held
  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal)));

  // R10: reset clears the output flags
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_illegal));

  // R8: an illegal code returns the old destination
  a_r8_illegal_keeps_old: assert property (@(posedge clk) disable iff (rst)
    (in_fire && illegal) |=> (out_illegal && out_data == $past(in_old)));

  // R8: an illegal code selects no product lane
  a_r8_illegal_no_product: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (take_prod == '0));

  // R5: a lane never takes both the product and the old value
  a_r5_sel_exclusive: assert property (@(posedge clk) disable iff (rst)
    (take_prod & take_old) == '0);

  // R2: four-lane mode keeps the upper destination
  a_r2_quad_keeps_upper: assert property (@(posedge clk) disable iff (rst)
    (in_fire && in_mode == MD_QUAD4) |=>
      (out_data[DW-1:QUAD_W] == $past(in_old[DW-1:QUAD_W])));

endmodule

// File: tb/pmlo_unit_tb_top.sv
`timescale 1ns/1ps
module pmlo_unit_tb_top;

  localparam int DW = 512;
  localparam int NL = 32;

  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  len;
    logic [31:0] mask;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 32'h0000_0000, 8'd1},
    '{3'd0, 2'd2, 32'hFFFF_FFFF, 8'd2},
    '{3'd1, 2'd0, 32'h0000_0000, 8'd3},
    '{3'd1, 2'd2, 32'hFFFF_FFFF, 8'd4},
    '{3'd2, 2'd0, 32'h0000_0000, 8'd5},
    '{3'd2, 2'd1, 32'h0000_0000, 8'd6},
    '{3'd2, 2'd2, 32'h0000_0000, 8'd7},
    '{3'd3, 2'd0, 32'h0000_00A5, 8'd8},
    '{3'd3, 2'd1, 32'h0000_F0F0, 8'd9},
    '{3'd3, 2'd2, 32'hA5A5_5A5A, 8'd10},
    '{3'd4, 2'd0, 32'h0000_003C, 8'd11},
    '{3'd4, 2'd2, 32'h1234_8765, 8'd12},
    '{3'd5, 2'd0, 32'h0000_0000, 8'd13},
    '{3'd2, 2'd3, 32'h0000_0000, 8'd14},
    '{3'd7, 2'd1, 32'h0000_FFFF, 8'd15}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [2:0]    in_mode;
  logic [1:0]    in_len;
  logic [NL-1:0] in_mask;
  logic [DW-1:0] in_src1;
  logic [DW-1:0] in_src2;
  logic [DW-1:0] in_old;
  logic          out_valid;
  logic          out_ready;
  logic [DW-1:0] out_data;
  logic          out_illegal;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pmlo_unit dut_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_mode     (in_mode),
    .in_len      (in_len),
    .in_mask     (in_mask),
    .in_src1     (in_src1),
    .in_src2     (in_src2),
    .in_old      (in_old),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_illegal (out_illegal)
  );

  function automatic logic [DW-1:0] gen(input int seed, input int which);
    logic [DW-1:0] v;
    for (int j = 0; j < NL; j++) begin
      int x;
      x = seed * 7919 + which * 12345 + j * 4421 + j * j * 31 + seed * which * j * 97;
      v[16*j +: 16] = 16'(x ^ (x >> 5));
    end
    return v;
  endfunction

  // Reference model built from the requirements.
  function automatic logic [DW-1:0] ref_out(input logic [2:0] mode, input logic [1:0] len,
      input logic [NL-1:0] mask, input logic [DW-1:0] a, input logic [DW-1:0] b,
      input logic [DW-1:0] old, output logic ill);
    logic [DW-1:0] r;
    int n;
    ill = 1'b0;
    r   = '0;
    if (mode > 3'd4 || (mode >= 3'd2 && len == 2'd3)) begin
      ill = 1'b1;
      return old;
    end
    n = (mode == 3'd0) ? 4 : (mode == 3'd1) ? 8 : (8 << len);
    for (int j = 0; j < NL; j++) begin
      int p;
      p = int'($signed(a[16*j +: 16])) * int'($signed(b[16*j +: 16]));
      if (j >= n) r[16*j +: 16] = (mode <= 3'd1) ? old[16*j +: 16] : 16'h0;
      else if (mode >= 3'd3 && !mask[j]) r[16*j +: 16] = (mode == 3'd3) ? old[16*j +: 16] : 16'h0;
      else r[16*j +: 16] = p[15:0];
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] mode, input logic [1:0] len);
    if (mode > 3'd4 || (mode >= 3'd2 && len == 2'd3)) return "R8";
    case (mode)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk_vec(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s data got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%b exp=%b", tag, what, got, exp);
    end
  endtask

  task automatic put(input logic [2:0] m, input logic [1:0] l, input logic [NL-1:0] k,
      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] o);
    in_mode  = m;
    in_len   = l;
    in_mask  = k;
    in_src1  = a;
    in_src2  = b;
    in_old   = o;
    in_valid = 1'b1;
  endtask

  // Drive on a falling edge, accept on the rising edge, sample on the next falling edge.
  task automatic send(input logic [2:0] m, input logic [1:0] l, input logic [NL-1:0] k,
      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] o);
    @(negedge clk);
    put(m, l, k, a, b, o);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R9 watchdog got=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] a, b, o, e, e2, a2, b2, o2;
    logic          ill;

    rst       = 1'b1;
    in_valid  = 1'b0;
    out_ready = 1'b1;
    in_mode   = '0;
    in_len    = '0;
    in_mask   = '0;
    in_src1   = '0;
    in_src2   = '0;
    in_old    = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_bit("R10", "out_valid after reset", out_valid, 1'b0);
    chk_bit("R10", "out_illegal after reset", out_illegal, 1'b0);
    chk_bit("R9", "in_ready when empty", in_ready, 1'b1);
    rst = 1'b0;

    // Table of modes, lengths and masks.
    for (int i = 0; i < NV; i++) begin
      a = gen(int'(VECS[i].seed), 1);
      b = gen(int'(VECS[i].seed), 2);
      o = gen(int'(VECS[i].seed), 3);
      e = ref_out(VECS[i].mode, VECS[i].len, VECS[i].mask, a, b, o, ill);
      send(VECS[i].mode, VECS[i].len, VECS[i].mask, a, b, o);
      chk_bit("R9", "out_valid after accept", out_valid, 1'b1);
      chk_vec(tag_of(VECS[i].mode, VECS[i].len), out_data, e);
      chk_bit("R8", "out_illegal", out_illegal, ill);
    end

    // R1: signed wrap corners in lanes 0..3, constant expected values.
    a = '0;
    b = '0;
    a[63:0] = 64'h8000_7FFF_FFFF_8000;
    b[63:0] = 64'hFFFF_7FFF_FFFF_8000;
    send(3'd2, 2'd0, '0, a, b, {DW{1'b1}});
    chk_vec("R1", out_data, {448'h0, 64'h8000_0001_0001_0000});

    // R1: whole vector against full signed products.
    a = gen(77, 1) | {32{16'h8000}};
    b = gen(77, 2);
    e = ref_out(3'd2, 2'd2, '0, a, b, '0, ill);
    send(3'd2, 2'd2, '0, a, b, gen(77, 3));
    chk_vec("R1", out_data, e);

    // R7: mask bits only above the active 8 lanes.
    a = gen(40, 1);
    b = gen(40, 2);
    o = gen(40, 3);
    e = {384'h0, o[127:0]};
    send(3'd3, 2'd0, 32'hFFFF_FF00, a, b, o);
    chk_vec("R7", out_data, e);
    e = '0;
    send(3'd4, 2'd0, 32'hFFFF_FF00, a, b, o);
    chk_vec("R7", out_data, e);

    // R9: idle after a taken result.
    @(negedge clk);
    chk_bit("R9", "out_valid idle", out_valid, 1'b0);

    // R9: back-pressure hold, then drain and accept the next beat.
    a  = gen(50, 1);
    b  = gen(50, 2);
    o  = gen(50, 3);
    e  = ref_out(3'd2, 2'd1, '0, a, b, o, ill);
    a2 = gen(51, 1);
    b2 = gen(51, 2);
    o2 = gen(51, 3);
    e2 = ref_out(3'd4, 2'd1, 32'h0000_5A5A, a2, b2, o2, ill);
    @(negedge clk);
    out_ready = 1'b0;
    put(3'd2, 2'd1, '0, a, b, o);
    @(posedge clk);
    @(negedge clk);
    chk_bit("R9", "out_valid stalled", out_valid, 1'b1);
    chk_vec("R9", out_data, e);
    chk_bit("R9", "in_ready stalled", in_ready, 1'b0);
    put(3'd4, 2'd1, 32'h0000_5A5A, a2, b2, o2);
    @(posedge clk);
    @(negedge clk);
    chk_vec("R9", out_data, e);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec("R9", out_data, e2);
    @(posedge clk);
    @(negedge clk);
    chk_bit("R9", "out_valid drained", out_valid, 1'b0);

    // R10: reset while an illegal result is held.
    out_ready = 1'b0;
    send(3'd6, 2'd0, '0, a, b, o);
    chk_bit("R8", "out_illegal held", out_illegal, 1'b1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_bit("R10", "out_valid in reset", out_valid, 1'b0);
    chk_bit("R10", "out_illegal in reset", out_illegal, 1'b0);
    rst       = 1'b0;
    out_ready = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule